// File: doc/BRIEF.md
# Explicit-Length Packed String Comparator

The unit compares two 128-bit string fragments. Each fragment comes with a signed 32-bit length. An 8-bit control byte sets three things: the element size (bytes or 16-bit words), one of four aggregation schemes, and which end of the aggregated result vector the index is taken from. Each signed length becomes an effective element count, which is its absolute value clamped to the number of elements in the vector. Elements at or past that count are invalid. All element pairs are compared unsigned. The comparison matrix is reduced to one bit per operand-2 position, and the unit returns the position of the lowest or highest set bit. When no bit is set, it returns the element count.

A caller presents both fragments, both lengths and the control byte together with a one-cycle valid strobe. The index appears on the following clock edge with a matching one-cycle output-valid pulse. The index register holds its value between results.

Top module: `str_cmp_unit`

## Requirements
- R1: ctl_i bit 0 selects the element size. At 0 there are 16 byte elements, element i at bits 8i+7:8i. At 1 there are 8 word elements, element i at bits 16i+15:16i. The element count n is 16 or 8 to match.
- R2: The effective length of each operand is |len| when |len| <= n, and n otherwise. This holds for negative inputs, including -2^31.
- R3: An element at or beyond its operand's effective length is invalid. A result bit at a position at or beyond operand 2's effective length is always clear.
- R4: With ctl_i bits 3:2 = 00 (any-match), result bit j is set when operand-2 element j equals at least one valid operand-1 element.
- R5: With ctl_i bits 3:2 = 01 (ranges), operand-1 elements 2k and 2k+1 form an inclusive lower/upper pair. The pair counts only if both elements are valid. Result bit j is set when operand-2 element j falls inside any counting pair.
- R6: With ctl_i bits 3:2 = 10 (each-match), result bit j is set when element j of both operands is valid and the two are equal.
- R7: With ctl_i bits 3:2 = 11 (ordered), result bit j is set when, for every valid operand-1 element k with j+k < n, operand-2 element j+k is valid and equal to it. Operand-1 elements whose position j+k falls past the vector's end are not checked.
- R8: With ctl_i bit 6 = 0, the index is the lowest set result bit. With bit 6 = 1, it is the highest set result bit.
- R9: When no result bit is set, idx_o is n: 16 in byte mode, 8 in word mode.
- R10: idx_o and valid_o update on the clock edge that samples valid_i high, and valid_o is high for exactly that one cycle. idx_o holds while valid_i is low. ctl_i bits 1, 4, 5 and 7 have no effect.
- R11: While rst_ni is low, valid_o is 0 and idx_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request strobe |
| src1_i | input | 128 | Operand 1 fragment (pattern, set or bounds) |
| src2_i | input | 128 | Operand 2 fragment (searched string) |
| len1_i | input | 32 | Signed length of operand 1 |
| len2_i | input | 32 | Signed length of operand 2 |
| ctl_i | input | 8 | Control byte |
| valid_o | output | 1 | Result valid pulse |
| idx_o | output | 5 | Result index |

## Verification
Length masking and the empty-result fallback can both act in the same cycle. A match that the aggregation finds past operand 2's effective length must be dropped, and the index must then fall back to n, not point at that position. The bench provokes this with strings whose only match lies beyond a short, negative or zero operand-2 length, in both index directions. It also covers the ordered scheme's truncated tail match. Each case is judged against a bench model that clamps the lengths independently and applies the mask before it searches for the index.

// File: rtl/str_cmp_pkg.sv
package str_cmp_pkg;
  localparam int unsigned DATA_W = 128;
  localparam int unsigned LEN_W  = 32;
  localparam int unsigned NB     = DATA_W / 8;
  localparam int unsigned NW     = DATA_W / 16;
  localparam int unsigned CNT_W  = $clog2(NB + 1);

  localparam int unsigned CTL_WORD = 0;
  localparam int unsigned CTL_AGG  = 2;
  localparam int unsigned CTL_MSB  = 6;

  typedef enum logic [1:0] {
    AGG_ANY   = 2'b00,
    AGG_RANGE = 2'b01,
    AGG_EACH  = 2'b10,
    AGG_ORD   = 2'b11
  } agg_e;
endpackage

// File: rtl/str_len_sat.sv
module str_len_sat #(
  parameter int unsigned LEN_W = 32,
  parameter int unsigned CNT_W = 5,
  parameter int unsigned NB    = 16,
  parameter int unsigned NW    = 8
) (
  input  logic signed [LEN_W-1:0] len_i,
  input  logic                    word_i,
  output logic [CNT_W-1:0]        eff_o
);
  logic signed [LEN_W-1:0] lim;
  logic signed [LEN_W-1:0] neg;

  assign lim = word_i ? LEN_W'(NW) : LEN_W'(NB);
  assign neg = -len_i;

  always_comb begin
    if (len_i > lim || len_i < -lim) eff_o = CNT_W'(lim);
    else if (len_i < 0)              eff_o = CNT_W'(neg);
    else                             eff_o = CNT_W'(len_i);
  end
endmodule

// File: rtl/str_cmp_matrix.sv
module str_cmp_matrix
  import str_cmp_pkg::*;
#(
  parameter int unsigned DW  = 128,
  parameter int unsigned EW  = 8,
  parameter int unsigned CW  = 5,
  localparam int unsigned NE = DW / EW
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [CW-1:0] la_i,
  input  logic [CW-1:0] lb_i,
  input  agg_e          agg_i,
  output logic [NE-1:0] res_o
);
  logic [EW-1:0]          ea [NE];
  logic [EW-1:0]          eb [NE];
  logic [NE-1:0]          va, vb;
  logic [NE-1:0][NE-1:0]  eq;  // eq[i][j]: a elem i == b elem j

  for (genvar gi = 0; gi < NE; gi++) begin : g_unpack
    assign ea[gi] = a_i[gi*EW +: EW];
    assign eb[gi] = b_i[gi*EW +: EW];
    assign va[gi] = la_i > CW'(gi);
    assign vb[gi] = lb_i > CW'(gi);
    for (genvar gj = 0; gj < NE; gj++) begin : g_eq
      assign eq[gi][gj] = ea[gi] == eb[gj];
    end
  end

  for (genvar gj = 0; gj < NE; gj++) begin : g_col
    logic any_hit, rng_hit, each_hit, ord_hit, sel;

    always_comb begin
      any_hit = 1'b0;
      for (int i = 0; i < NE; i++) any_hit |= va[i] & eq[i][gj];
    end

    always_comb begin
      rng_hit = 1'b0;
      for (int k = 0; k < NE / 2; k++)
        rng_hit |= va[2*k+1] & (eb[gj] >= ea[2*k]) & (eb[gj] <= ea[2*k+1]);
    end

    assign each_hit = va[gj] & eq[gj][gj];

    // pattern tail running past the vector end is not checked
    always_comb begin
      ord_hit = 1'b1;
      for (int k = 0; k < NE - gj; k++)
        ord_hit &= ~va[k] | (vb[gj+k] & eq[k][gj+k]);
    end

    always_comb begin
      unique case (agg_i)
        AGG_ANY:   sel = any_hit;
        AGG_RANGE: sel = rng_hit;
        AGG_EACH:  sel = each_hit;
        default:   sel = ord_hit;
      endcase
    end

    assign res_o[gj] = vb[gj] & sel;
  end
endmodule

// File: rtl/str_idx_sel.sv
module str_idx_sel #(
  parameter int unsigned NE_MAX = 16,
  parameter int unsigned IDX_W  = 5
) (
  input  logic [NE_MAX-1:0] res_i,
  input  logic              word_i,
  input  logic              msb_i,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    idx_o = word_i ? IDX_W'(NE_MAX / 2) : IDX_W'(NE_MAX);
    if (msb_i) begin
      for (int i = 0; i < NE_MAX; i++)
        if (res_i[i]) idx_o = IDX_W'(i);
    end else begin
      for (int i = NE_MAX - 1; i >= 0; i--)
        if (res_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/str_cmp_unit.sv
module str_cmp_unit
  import str_cmp_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [DATA_W-1:0]       src1_i,
  input  logic [DATA_W-1:0]       src2_i,
  input  logic signed [LEN_W-1:0] len1_i,
  input  logic signed [LEN_W-1:0] len2_i,
  input  logic [7:0]              ctl_i,
  output logic                    valid_o,
  output logic [CNT_W-1:0]        idx_o
);
  logic              word;
  logic              msb;
  agg_e              agg;
  logic              unused_ctl;
  logic signed [LEN_W-1:0] len_v [2];
  logic [CNT_W-1:0]  eff_v [2];
  logic [CNT_W-1:0]  eff_a_w, eff_b_w;
  logic [NB-1:0]     res_v [2];
  logic [NB-1:0]     res_sel;
  logic [CNT_W-1:0]  idx_c;

  assign word       = ctl_i[CTL_WORD];
  assign msb        = ctl_i[CTL_MSB];
  assign agg        = agg_e'(ctl_i[CTL_AGG +: 2]);
  assign unused_ctl = ^{ctl_i[7], ctl_i[5:4], ctl_i[1]};

  assign len_v[0] = len1_i;
  assign len_v[1] = len2_i;

  for (genvar g = 0; g < 2; g++) begin : g_len
    str_len_sat #(
      .LEN_W(LEN_W), .CNT_W(CNT_W), .NB(NB), .NW(NW)
    ) u_sat (
      .len_i (len_v[g]),
      .word_i(word),
      .eff_o (eff_v[g])
    );
  end

  assign eff_a_w = eff_v[0];
  assign eff_b_w = eff_v[1];

  // g=0 byte elements, g=1 word elements
  for (genvar g = 0; g < 2; g++) begin : g_mat
    localparam int unsigned EW = 8 << g;
    localparam int unsigned NE = DATA_W / EW;
    logic [NE-1:0] r;

    str_cmp_matrix #(
      .DW(DATA_W), .EW(EW), .CW(CNT_W)
    ) u_mat (
      .a_i  (src1_i),
      .b_i  (src2_i),
      .la_i (eff_a_w),
      .lb_i (eff_b_w),
      .agg_i(agg),
      .res_o(r)
    );
    assign res_v[g] = NB'(r);
  end

  assign res_sel = word ? res_v[1] : res_v[0];

  str_idx_sel #(
    .NE_MAX(NB), .IDX_W(CNT_W)
  ) u_idx (
    .res_i (res_sel),
    .word_i(word),
    .msb_i (msb),
    .idx_o (idx_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      idx_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) idx_o <= idx_c;
    end
  end
endmodule

// File: rtl/str_cmp_chk.sv
module str_cmp_chk #(
  parameter int unsigned CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             word_i,
  input logic [CNT_W-1:0] eff_a_i,
  input logic [CNT_W-1:0] eff_b_i,
  input logic             valid_o,
  input logic [CNT_W-1:0] idx_o
);
  logic [CNT_W-1:0] lim;
  assign lim = word_i ? CNT_W'(8) : CNT_W'(16);

  p_valid_follow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_valid_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  p_idx_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(idx_o));

  p_len_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_a_i <= lim) && (eff_b_i <= lim));

  p_idx_masked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (idx_o < $past(eff_b_i)) || (idx_o == $past(lim)));

  p_empty_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && eff_b_i == '0) |=> idx_o == $past(lim));
endmodule

bind str_cmp_unit str_cmp_chk #(.CNT_W(str_cmp_pkg::CNT_W)) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .word_i (ctl_i[0]),
  .eff_a_i(eff_a_w),
  .eff_b_i(eff_b_w),
  .valid_o(valid_o),
  .idx_o  (idx_o)
);

// File: tb/str_cmp_unit_tb_top.sv
module str_cmp_unit_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] src1_i = '0, src2_i = '0;
  logic signed [31:0] len1_i = '0, len2_i = '0;
  logic [7:0]   ctl_i = '0;
  logic         valid_o;
  logic [4:0]   idx_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  str_cmp_unit dut_i (
    .clk_i, .rst_ni, .valid_i, .src1_i, .src2_i,
    .len1_i, .len2_i, .ctl_i, .valid_o, .idx_o
  );

  function automatic logic [127:0] str(string s);
    logic [127:0] v = '0;
    for (int i = 0; i < s.len() && i < 16; i++) v[i*8 +: 8] = s[i];
    return v;
  endfunction

  function automatic int unsigned el(logic [127:0] v, int i, bit w);
    return w ? int'(v[i*16 +: 16]) : int'(v[i*8 +: 8]);
  endfunction

  function automatic int effl(logic signed [31:0] l, int n);
    longint x = l;
    if (x < 0) x = -x;
    return (x > n) ? n : int'(x);
  endfunction

  function automatic int ref_idx(logic [127:0] a, logic [127:0] b,
                                 logic signed [31:0] l1, logic signed [31:0] l2,
                                 logic [7:0] c);
    bit w = c[0];
    int n = w ? 8 : 16;
    int la = effl(l1, n);
    int lb = effl(l2, n);
    bit r [16];
    int res;
    for (int j = 0; j < n; j++) begin
      bit m = 0;
      case (c[3:2])
        2'b00: for (int i = 0; i < la; i++) if (el(a, i, w) == el(b, j, w)) m = 1;
        2'b01: for (int k = 0; 2*k+1 < la; k++)
                 if (el(b, j, w) >= el(a, 2*k, w) && el(b, j, w) <= el(a, 2*k+1, w)) m = 1;
        2'b10: m = (j < la) && (el(a, j, w) == el(b, j, w));
        default: begin
          m = 1;
          for (int k = 0; k < n - j; k++)
            if (k < la && (j + k >= lb || el(a, k, w) != el(b, j + k, w))) m = 0;
        end
      endcase
      r[j] = m && (j < lb);
    end
    res = n;
    for (int j = 0; j < n; j++) if (r[j]) begin
      if (c[6]) res = j;
      else if (res == n) res = j;
    end
    return res;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one request; optionally check idle hold; exp<0 uses model
  task automatic run(logic [127:0] a, logic [127:0] b, int l1, int l2,
                     logic [7:0] c, int exp, string req, bit hold);
    int e;
    @(negedge clk_i);
    src1_i = a; src2_i = b; len1_i = l1; len2_i = l2; ctl_i = c; valid_i = 1'b1;
    e = (exp < 0) ? ref_idx(a, b, l1, l2, c) : exp;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(valid_o === 1'b1, {req, " valid"}, int'(valid_o), 1);
    chk(idx_o === 5'(e), req, int'(idx_o), e);
    if (hold) begin
      src1_i = ~a; len2_i = 3; ctl_i = c ^ 8'h40;
      @(negedge clk_i);
      chk(valid_o === 1'b0, "R10 pulse", int'(valid_o), 0);
      chk(idx_o === 5'(e), "R10 hold", int'(idx_o), e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(valid_o === 1'b0, "R11 valid", int'(valid_o), 0);
    chk(idx_o === 5'd0, "R11 idx", int'(idx_o), 0);
    rst_ni = 1'b1;

    // R4 any-match
    run(str("xyc"), str("0123456c89"), 3, 10, 8'h00, 7, "R4", 1);
    run(str("xyc"), str("0123456c89"), 3, 10, 8'h40, 7, "R4 msb", 0);
    // R3 match beyond operand-2 length is masked; falls back to n
    run(str("xyc"), str("0123456c89"), 3, 7, 8'h00, 16, "R3", 0);
    run(str("xyc"), str("0123456c89"), 3, -7, 8'h40, 16, "R3 neg", 0);
    // R3 operand-1 element past its length does not match
    run(str("xyc"), str("0123456c89"), 2, 10, 8'h00, 16, "R3 a", 0);
    // R5 ranges
    run(str("az"), str("12c4q"), 2, 5, 8'h04, 2, "R5", 0);
    run(str("az"), str("12c4q"), 2, 5, 8'h44, 4, "R5 msb", 0);
    run(str("az"), str("12c4q"), 1, 5, 8'h04, 16, "R5 half pair", 0);
    // R6 each-match
    run(str("abcd"), str("abXd"), 4, 4, 8'h08, 0, "R6", 0);
    run(str("abcd"), str("abXd"), 4, 4, 8'h48, 3, "R6 msb", 0);
    run(str("Zbcd"), str("abXd"), 4, 3, 8'h08, 1, "R6 len", 0);
    // R7 ordered
    run(str("lo"), str("hello"), 2, 5, 8'h0C, 3, "R7", 0);
    run(str("ox"), str("hellohellohelloo"), 2, 16, 8'h0C, 15, "R7 tail", 0);
    run(str("ox"), str("hello"), 2, 5, 8'h0C, 16, "R7 short", 0);
    run(str("lo"), str("hello"), 0, 5, 8'h0C, 0, "R7 empty pattern", 0);
    // R9 empty result, both sizes
    run(str("abc"), str("abc"), 3, 0, 8'h00, 16, "R9 byte", 0);
    run(str("abc"), str("abc"), 3, 0, 8'h01, 8, "R9 word", 0);
    // R2 saturation and negative lengths
    run(str("q"), str("aaaaaaaaaaaaaaaq"), 1, 1000, 8'h00, 15, "R2 over", 0);
    run(str("q"), str("aaaaaaaaaaaaaaaq"), -1, 32'h80000000, 8'h00, 15, "R2 min", 0);
    run(str("q"), str("aaaaaaaaaaaaaaaq"), -17, -16, 8'h40, 15, "R2 neg", 0);
    run(str("q"), str("aaaaaaaaaaaaaaaq"), 1, -15, 8'h00, 16, "R2 neg short", 0);
    // R1 word elements: 16-bit halves must both match
    run({112'h0, 16'h6162}, {96'h0, 16'h6162, 16'h6261}, 1, 8, 8'h01, 1, "R1 word", 0);
    run({112'h0, 16'h6162}, {96'h0, 16'h6162, 16'h6261}, 1, 100, 8'h41, 1, "R1 word sat", 0);
    run({112'h0, 16'h6162}, {96'h0, 16'h6162, 16'h6261}, 2, 8, 8'h00, 0, "R1 byte", 1);
    // R10 ignored control bits
    run(str("lo"), str("hello"), 2, 5, 8'hBE, 3, "R10 ignored bits", 1);

    // R4 R5 R6 R7 R8 random against model
    for (int it = 0; it < 400; it++) begin
      logic [127:0] a, b;
      int l1, l2;
      for (int i = 0; i < 16; i++) begin
        a[i*8 +: 8] = 8'($urandom_range(3));
        b[i*8 +: 8] = 8'($urandom_range(3));
      end
      case ($urandom_range(3))
        0: begin l1 = $urandom_range(20) - 10; l2 = $urandom_range(40) - 20; end
        1: begin l1 = 16; l2 = -16; end
        2: begin l1 = int'($urandom()); l2 = $urandom_range(16); end
        default: begin l1 = $urandom_range(4); l2 = 32'h80000000; end
      endcase
      run(a, b, l1, l2, 8'($urandom()), -1, "R8 random", it % 37 == 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule